// File: doc/BRIEF.md
# Flash Controller Status Flags

This block keeps the four live status flags of a flash memory controller: whether the controller can take a new command, whether the array is in power-reduction mode, whether the page buffer holds words not yet committed, and whether a program or erase is on hold. Each flag is a register that changes only in response to its own set and clear events. The block does not time the flash array and does not execute commands.

The controller feeds the block a pulse for each word written into the page buffer, a command opcode with a valid strobe, sleep entry and exit events, a configuration bit that ties power reduction to sleep, a strobe for bus accesses to the memory, and busy and suspend levels from the operation engine. The flags appear in the low bits of a read-only status word whose upper bits are always zero. Every flag takes effect one clock after the event that causes it.

Top module: `flash_status_flags`

## Requirements
- R1: While `rst_ni` is low, `status_o` reads 0x0000, whatever the other inputs do.
- R2: A `word_wr_i` pulse sets the buffer-loaded flag (bit 2) on the next clock, unless a buffer-clearing command is accepted in the same cycle.
- R3: An accepted command with opcode 0x04 (write page), 0x05 (write quad word) or 0x15 (clear page buffer) clears bit 2 on the next clock. Other opcodes leave bit 2 unchanged.
- R4: If a word write and an accepted buffer-clearing command occur in the same cycle, bit 2 is 0 on the next clock.
- R5: The power-reduction flag (bit 1) is set on the next clock by an accepted opcode 0x12, or by `sleep_enter_i` while `pr_on_sleep_i` is 1. `sleep_enter_i` while `pr_on_sleep_i` is 0 has no effect.
- R6: Bit 1 is cleared on the next clock by `bus_access_i`, by an accepted opcode 0x13, or by `sleep_exit_i` while `pr_on_sleep_i` is 1. `sleep_exit_i` while `pr_on_sleep_i` is 0 has no effect.
- R7: If an event that sets bit 1 and an event that clears it occur in the same cycle, bit 1 is 0 on the next clock.
- R8: The ready flag (bit 0) equals the inverse of `engine_busy_i` from the previous clock. Its reset value is 0.
- R9: The suspend flag (bit 3) equals `engine_susp_i` from the previous clock.
- R10: A command is accepted only if `cmd_valid_i` is high while bit 0 is 1. A command presented while bit 0 is 0 leaves bits 1 and 2 unchanged.
- R11: Bits 15:4 of `status_o` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_wr_i | input | 1 | Pulse: one word written into the page buffer |
| cmd_valid_i | input | 1 | Qualifies `cmd_op_i` |
| cmd_op_i | input | 7 | Command opcode |
| sleep_enter_i | input | 1 | Pulse: the system enters sleep |
| sleep_exit_i | input | 1 | Pulse: the system leaves sleep |
| pr_on_sleep_i | input | 1 | 1: power reduction follows sleep entry and exit |
| bus_access_i | input | 1 | Pulse: bus access to the memory |
| engine_busy_i | input | 1 | Program or erase in progress |
| engine_susp_i | input | 1 | Write or erase operation suspended |
| status_o | output | 16 | Status word: bit 0 ready, bit 1 power reduction, bit 2 buffer loaded, bit 3 suspended |

## Verification
The assertions check on every cycle that ready and suspend follow the engine levels with one cycle of delay, that a word write without a command sets the loaded flag, that the loaded flag holds when nothing can touch it, that a bus access always leaves power reduction off, that a command arriving while busy changes nothing, and that the upper bits stay zero. Which opcodes clear which flag, whether sleep events act under each setting of the configuration bit, and that clears win when they collide with sets in the same cycle all depend on specific sequences of events. The bench's directed scenarios cover these.

// File: rtl/flash_status_flags.sv
module flash_status_flags #(
  parameter int CMD_W = 7,
  parameter int STAT_W = 16,
  parameter logic [CMD_W-1:0] OP_WR_PAGE = 7'h04,
  parameter logic [CMD_W-1:0] OP_WR_QUAD = 7'h05,
  parameter logic [CMD_W-1:0] OP_BUF_CLR = 7'h15,
  parameter logic [CMD_W-1:0] OP_PR_SET  = 7'h12,
  parameter logic [CMD_W-1:0] OP_PR_CLR  = 7'h13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_wr_i,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_op_i,
  input  logic              sleep_enter_i,
  input  logic              sleep_exit_i,
  input  logic              pr_on_sleep_i,
  input  logic              bus_access_i,
  input  logic              engine_busy_i,
  input  logic              engine_susp_i,
  output logic [STAT_W-1:0] status_o
);
  localparam int PAD_W = STAT_W - 4;

  logic ready_q, pr_q, loaded_q, susp_q;
  logic cmd_ok, flush, pr_set, pr_clr;

  assign cmd_ok = cmd_valid_i & ready_q;
  assign flush  = cmd_ok & (cmd_op_i == OP_WR_PAGE || cmd_op_i == OP_WR_QUAD ||
                            cmd_op_i == OP_BUF_CLR);
  assign pr_set = (cmd_ok & (cmd_op_i == OP_PR_SET)) | (sleep_enter_i & pr_on_sleep_i);
  assign pr_clr = (cmd_ok & (cmd_op_i == OP_PR_CLR)) | (sleep_exit_i & pr_on_sleep_i) |
                  bus_access_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q  <= 1'b0;
      pr_q     <= 1'b0;
      loaded_q <= 1'b0;
      susp_q   <= 1'b0;
    end else begin
      ready_q <= ~engine_busy_i;
      susp_q  <= engine_susp_i;
      if (flush)          loaded_q <= 1'b0;
      else if (word_wr_i) loaded_q <= 1'b1;
      if (pr_clr)         pr_q <= 1'b0;
      else if (pr_set)    pr_q <= 1'b1;
    end
  end

  assign status_o = {{PAD_W{1'b0}}, susp_q, loaded_q, pr_q, ready_q};

  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;

  p_ready_follows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> status_o[0] == !$past(engine_busy_i));

  p_susp_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> status_o[3] == $past(engine_susp_i));

  p_load_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(word_wr_i && !cmd_valid_i) |-> status_o[2]);

  p_load_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(!word_wr_i && !cmd_valid_i) |-> status_o[2] == $past(status_o[2]));

  p_bus_wakes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(bus_access_i) |-> !status_o[1]);

  p_busy_rejects_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(cmd_valid_i && !status_o[0] && !word_wr_i && !bus_access_i &&
                    !sleep_enter_i && !sleep_exit_i)
    |-> $stable(status_o[2:1]));

  always_comb p_upper_zero_r11: assert (status_o[STAT_W-1:4] == '0);
endmodule

// File: tb/sim_flash_status_flags.sv
module sim_flash_status_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 0, cv = 0, se = 0, sx = 0, cfg = 0, bus = 0, busy = 0, susp = 0;
  logic [6:0] op = '0;
  logic [15:0] st;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_status_flags u0 (
    .clk_i(clk), .rst_ni(rst_n), .word_wr_i(wr), .cmd_valid_i(cv), .cmd_op_i(op),
    .sleep_enter_i(se), .sleep_exit_i(sx), .pr_on_sleep_i(cfg), .bus_access_i(bus),
    .engine_busy_i(busy), .engine_susp_i(susp), .status_o(st));

  task automatic check(string req, logic [15:0] exp);
    checks++;
    if (st !== exp) begin
      errors++;
      $display("FAIL %s: status=%h expected=%h", req, st, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    wr = 0; cv = 0; se = 0; sx = 0; bus = 0;
  endtask

  task automatic cmd(logic [6:0] c);
    op = c; cv = 1; step();
  endtask

  task automatic t_reset();
    wr = 1; se = 1; cfg = 1; susp = 1;
    repeat (3) @(negedge clk);
    check("R1", 16'h0000);
    wr = 0; se = 0; cfg = 0; susp = 0;
    rst_n = 1;
    step();
    check("R8", 16'h0001);
  endtask

  task automatic t_load();
    wr = 1; step();
    check("R2", 16'h0005);
    cmd(7'h12); check("R3 other opcode keeps load", 16'h0007);
    cmd(7'h13); check("R3", 16'h0005);
    cmd(7'h04); check("R3 write page", 16'h0001);
    wr = 1; step(); cmd(7'h05); check("R3 write quad", 16'h0001);
    wr = 1; step(); cmd(7'h15); check("R3 buffer clear", 16'h0001);
    wr = 1; cv = 1; op = 7'h15; step();
    check("R4", 16'h0001);
    wr = 1; cv = 1; op = 7'h13; step();
    check("R4 non-clearing opcode", 16'h0005);
    cmd(7'h15);
  endtask

  task automatic t_prm();
    cfg = 0; se = 1; step(); check("R5 sleep cfg=0", 16'h0001);
    cfg = 1; se = 1; step(); check("R5 sleep cfg=1", 16'h0003);
    cfg = 0; sx = 1; step(); check("R6 wake cfg=0", 16'h0003);
    cfg = 1; sx = 1; step(); check("R6 wake cfg=1", 16'h0001);
    cmd(7'h12); check("R5 command", 16'h0003);
    bus = 1; step(); check("R6 bus", 16'h0001);
    cmd(7'h12); cmd(7'h13); check("R6 command", 16'h0001);
    bus = 1; cv = 1; op = 7'h12; step(); check("R7 bus vs cmd", 16'h0001);
    cfg = 1; se = 1; sx = 1; step(); check("R7 sleep both", 16'h0001);
    cfg = 0;
  endtask

  task automatic t_engine();
    busy = 1; susp = 1; step();
    check("R9", 16'h0008);
    busy = 1; susp = 0; step();
    check("R8", 16'h0000);
    busy = 0; step();
    check("R8", 16'h0001);
  endtask

  task automatic t_reject();
    wr = 1; step(); cmd(7'h12); check("R10 setup", 16'h0007);
    busy = 1; step(); check("R8 busy", 16'h0006);
    cmd(7'h15); check("R10 buffer clear rejected", 16'h0006);
    cmd(7'h13); check("R10 pr clear rejected", 16'h0006);
    busy = 0; step(); check("R11 upper bits", 16'h0007);
    cmd(7'h13); cmd(7'h04); check("R10 accepted again", 16'h0001);
  endtask

  initial begin
    t_reset();
    t_load();
    t_prm();
    t_engine();
    t_reject();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule